// File: doc/BRIEF.md
# PHY Event Interrupt Collector

This block gathers single-cycle event pulses from a PHY's link and auto-negotiation logic into a sticky flag word, and gates that word with an enable mask to drive one level-sensitive interrupt line. Both words are reached through a simple synchronous register port. The flag word sits at management address 29 and the mask word at address 30.

Software enables the events it cares about by writing the mask. A typical choice is link down, negotiation complete and energy detect. When the interrupt line rises, software reads the flag word. That read returns every latched event and clears the flags in the same cycle, which acknowledges the interrupt. Events latch whether or not they are enabled. An event that arrives during the clearing read is kept, so it is never lost.

Top module: `phy_irq_collector`

## Requirements
- R1: After reset, the flag word and the mask word are zero, `irq` is low and `reg_rvalid` is low.
- R2: A pulse on `evt_pulse[k]` sets flag bit k+1 at the next clock edge, whether or not that bit is enabled. The flag bits are: bit 1 page received, bit 2 parallel-detect fault, bit 3 partner acknowledge, bit 4 link down, bit 5 remote fault, bit 6 negotiation complete, bit 7 energy detect. A set flag stays set until a clearing read.
- R3: A read of address 29 raises `reg_rvalid` one cycle later with `reg_rdata` equal to the flag word held before that edge, and the same edge clears the flag word.
- R4: An event pulse in the same cycle as a clearing read is absent from that read's data, and its flag bit is set after the read.
- R5: A write to address 30 stores `reg_wdata` bits 1 to 7 as the mask. A read of address 30 returns the mask, with bits 0 and 8 to 15 reading zero, and leaves both words unchanged.
- R6: After every clock edge, `irq` equals the OR over all bits of the flag word AND the mask word, both as updated at that edge.
- R7: Writing a mask bit whose flag is already pending raises `irq` right after the edge of that write.
- R8: While the mask is zero, `irq` stays low whatever events arrive.
- R9: Writes to address 29 or to any address other than 30 change neither word. Reads of an address other than 29 or 30 return zero.
- R10: Flag bits 0 and 8 to 15 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 7 | Event pulses; bit k maps to flag bit k+1 |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq | output | 1 | Level interrupt, high while an enabled flag is set |

## Verification
The assertions check the following on every cycle: the interrupt level agrees with the flag and mask registers, every event pulse sticks, a clearing read with no new event empties the flag word, the mask holds between writes, and a zero mask keeps the line low. Only the bench scenarios can show the other behaviours. These are the exact data a read returns, the keeping of an event that collides with a clearing read, the immediate interrupt after unmasking a pending flag, and the absence of side effects from stray addresses and from writes to the flag address.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int EV_PAGE_RX    = 0;
  localparam int EV_PD_FAULT   = 1;
  localparam int EV_PEER_ACK   = 2;
  localparam int EV_LINK_LOST  = 3;
  localparam int EV_RMT_FAULT  = 4;
  localparam int EV_NEG_DONE   = 5;
  localparam int EV_ENERGY     = 6;

  // Places an event-aligned field into a register-aligned word.
  function automatic logic [15:0] place_field(input logic [6:0] f, input int base);
    logic [15:0] w;
    w = '0;
    for (int i = 0; i < 7; i++) w[base + i] = f[i];
    return w;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               clr,
  output logic [NUM_EVT-1:0] flag_q,
  output logic [NUM_EVT-1:0] flag_d
);
  for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
    // new event wins over the clear
    assign flag_d[k] = evt[k] | (flag_q[k] & ~clr);
    always_ff @(posedge clk) begin
      if (rst) flag_q[k] <= 1'b0;
      else     flag_q[k] <= flag_d[k];
    end
  end

  p_evt_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flag_q & $past(evt)) == $past(evt)));
  p_clear_empties_r3: assert property (@(posedge clk) disable iff (rst)
    (clr && !(|evt)) |=> (flag_q == '0));
  p_hold_without_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [NUM_EVT-1:0] wfield,
  output logic [NUM_EVT-1:0] mask_q,
  output logic [NUM_EVT-1:0] mask_d
);
  assign mask_d = we ? wfield : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!we) |=> $stable(mask_q));
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= word;
    end
  end

  p_rvalid_follows_r3: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);
endmodule

// File: rtl/phy_irq_collector.sv
module phy_irq_collector
  import phy_irq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int NUM_EVT   = 7,
  parameter int EVT_BASE  = 1,
  parameter int FLAG_ADDR = 29,
  parameter int MASK_ADDR = 30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  output logic               irq
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
  localparam int FIELD_HI = EVT_BASE + NUM_EVT - 1;

  logic               hit_flag, hit_mask;
  logic               clr_rd, mask_we;
  logic [NUM_EVT-1:0] flag_q, flag_d, mask_q, mask_d;
  logic [DATA_W-1:0]  flag_word, mask_word, rd_word;

  assign hit_flag = (reg_addr == A_FLAG);
  assign hit_mask = (reg_addr == A_MASK);
  assign clr_rd   = reg_rd & hit_flag;
  assign mask_we  = reg_wr & hit_mask;

  irq_flag_bank #(.NUM_EVT(NUM_EVT)) u_flags (
    .clk(clk), .rst(rst), .evt(evt_pulse), .clr(clr_rd),
    .flag_q(flag_q), .flag_d(flag_d)
  );

  irq_mask_reg #(.NUM_EVT(NUM_EVT)) u_mask (
    .clk(clk), .rst(rst), .we(mask_we),
    .wfield(reg_wdata[FIELD_HI:EVT_BASE]),
    .mask_q(mask_q), .mask_d(mask_d)
  );

  always_comb begin
    flag_word = '0;
    mask_word = '0;
    flag_word[FIELD_HI:EVT_BASE] = flag_q;
    mask_word[FIELD_HI:EVT_BASE] = mask_q;
    if (hit_flag)      rd_word = flag_word;
    else if (hit_mask) rd_word = mask_word;
    else               rd_word = '0;
  end

  irq_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd(reg_rd), .word(rd_word),
    .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  // registered output computed from next-state values, so it tracks the registers
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flag_d & mask_d);
  end

  p_irq_level_r6: assert property (@(posedge clk) disable iff (rst)
    irq == (|(flag_q & mask_q)));
  p_zero_mask_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !irq);
  p_unused_flag_bits_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_rvalid && $past(clr_rd)) |-> (reg_rdata[EVT_BASE-1:0] == '0 && reg_rdata[DATA_W-1:FIELD_HI+1] == '0));
endmodule

// File: tb/phy_irq_collector_test.sv
module phy_irq_collector_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  evt_pulse = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_rvalid, irq;

  int total = 0, bad = 0;
  logic [15:0] mf = '0, mm = '0;
  logic [15:0] expq[$];
  string       reqq[$];

  always #4 clk = ~clk;

  phy_irq_collector uut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      if (expq.size() == 0) check("R3 unexpected rvalid", 16'h1, 16'h0);
      else check(reqq.pop_front(), reg_rdata, expq.pop_front());
    end
  end

  // driver: one cycle of stimulus, model update, then idle
  task automatic step(logic rd, logic wr, logic [4:0] a, logic [15:0] wd,
                      logic [6:0] ev, string req);
    logic [15:0] nf;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd; evt_pulse = ev;
    if (rd) begin
      expq.push_back(a == 5'd29 ? mf : (a == 5'd30 ? mm : 16'h0));
      reqq.push_back(req);
    end
    nf = ((rd && a == 5'd29) ? 16'h0 : mf) | {8'h0, ev, 1'b0};
    if (wr && a == 5'd30) mm = wd & 16'h00FE;
    mf = nf;
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; evt_pulse = '0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic chk_irq(string req);
    check(req, {15'h0, irq}, {15'h0, |(mf & mm)});
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {15'h0, irq}, 16'h0);
    check("R1 rvalid", {15'h0, reg_rvalid}, 16'h0);
    step(1, 0, 5'd29, 0, 0, "R1 flags zero");
    step(1, 0, 5'd30, 0, 0, "R1 mask zero");
    // R2/R8 events latch while masked, irq stays low
    step(0, 0, 0, 0, 7'b000_1001, "");
    chk_irq("R8 masked events");
    check("R8 irq low", {15'h0, irq}, 16'h0);
    step(0, 0, 0, 0, 7'b100_0000, "");
    // R7 unmask pending link-down (bit 4)
    step(0, 1, 5'd30, 16'h0010, 0, "");
    chk_irq("R7 unmask pending");
    check("R7 irq high", {15'h0, irq}, 16'h1);
    // R5 read mask, no side effect
    step(1, 0, 5'd30, 0, 0, "R5 mask readback");
    chk_irq("R5 no side effect");
    // R3 clearing read returns flags 0x92
    step(1, 0, 5'd29, 0, 0, "R3 R10 flag read");
    chk_irq("R3 cleared irq");
    check("R3 irq low", {15'h0, irq}, 16'h0);
    step(1, 0, 5'd29, 0, 0, "R3 empty after clear");
    // R5 typical set and unused mask bits
    step(0, 1, 5'd30, 16'hFFFF, 0, "");
    step(1, 0, 5'd30, 0, 0, "R5 unused mask bits");
    step(0, 1, 5'd30, 16'h00D0, 0, "");
    step(1, 0, 5'd30, 0, 0, "R5 typical set");
    // R6 each event, enabled or not
    for (int k = 0; k < 7; k++) begin
      step(0, 0, 0, 0, 7'(1 << k), "");
      chk_irq("R6 single event");
      step(1, 0, 5'd29, 0, 0, "R2 single event bit");
    end
    // R4 event during clearing read
    step(0, 0, 0, 0, 7'b000_0001, "");
    step(1, 0, 5'd29, 0, 7'b010_0000, "R4 read data excludes collider");
    chk_irq("R4 collider kept irq");
    step(1, 0, 5'd29, 0, 0, "R4 collider kept");
    // R9 stray accesses
    step(0, 0, 0, 0, 7'b000_1000, "");
    step(0, 1, 5'd29, 16'h0000, 0, "");
    step(0, 1, 5'd31, 16'h0000, 0, "");
    step(0, 1, 5'd0,  16'h00FE, 0, "");
    step(1, 0, 5'd7, 0, 0, "R9 stray read zero");
    chk_irq("R9 irq unchanged");
    step(1, 0, 5'd30, 0, 0, "R9 mask unchanged");
    step(1, 0, 5'd29, 0, 0, "R9 flags unchanged");
    // R8 zero mask silences everything
    step(0, 1, 5'd30, 16'h0000, 7'h7F, "");
    chk_irq("R8 zero mask");
    step(0, 0, 0, 0, 7'h7F, "");
    check("R8 irq low all events", {15'h0, irq}, 16'h0);
    step(1, 0, 5'd29, 0, 0, "R2 all flags latched");
    repeat (2) @(negedge clk);
    if (expq.size() != 0) check("R3 pending reads", 16'(expq.size()), 16'h0);
    finish_up();
  end
endmodule